// File: doc/BRIEF.md
# Split/Joined Timer-Counter with Capture

This block is a timer built around two 8-bit count registers. They can run as two separate halves or be chained into one 16-bit count. Each half, or the joined count, advances on one of two tick sources. The first is a programmable prescaler that fires once every P+1 clock cycles. The second is a one-cycle event strobe that has already been synchronised upstream. A two-bit mode field picks one of four arrangements:

| Mode | Low half | High half |
|------|----------|-----------|
| 0 | prescaled timer | prescaled timer |
| 1 | prescaled timer | event counter |
| 2 | joined 16-bit prescaled timer | (joined) |
| 3 | joined 16-bit event counter | (joined) |

Each count has a match register. When the count equals the match value on a tick, the count returns to zero and a sticky interrupt flag is set. Two capture strobes copy the live count into capture registers. In the split modes each strobe serves its own half. In the joined modes either strobe captures the whole 16-bit value.

Software reaches the block through a small register bus. A write lands on the clock edge. A read is combinational from the addressed register. The address map is:

| Address | Register | Access |
|---------|----------|--------|
| 0 | control: mode in bits [1:0], run enable in bit 2 | write/read |
| 1 | prescaler reload P | write/read |
| 2 | low match value | write/read |
| 3 | high match value | write/read |
| 4 | low count | read only |
| 5 | high count | read only |
| 6 | low capture | read only |
| 7 | high capture | read only |
| 8 | flags: bit 0 low, bit 1 high; writing 1 clears a bit | write/read |

Any other address reads as 0.

Top module: `dual_timer_cap`

## Requirements
- R1: After reset every readable register (addresses 0 to 8) reads 0, and both interrupt outputs are low.
- R2: While run is 1, the prescaler produces one tick every P+1 clock cycles, where P is the value at address 1. The first tick comes P+1 cycles after run takes effect. While run is 0 there are no prescaler ticks, and event strobes are not counted.
- R3: In mode 0, the low and high counts each advance by one on every prescaler tick, and each wraps against its own match value.
- R4: In mode 1, the low count advances on prescaler ticks and the high count advances on event strobes (`evt_stb` high in a cycle).
- R5: In mode 2, the value {high,low} is a single 16-bit count that advances on prescaler ticks, with a carry from the low half into the high half.
- R6: In mode 3, {high,low} is a single 16-bit count that advances on event strobes.
- R7: In a split mode (0 or 1), a half whose count equals its match value on one of its ticks goes to 0 on that edge and sets its flag. The low half sets flag bit 0 and the high half sets flag bit 1.
- R8: In a joined mode (2 or 3), only flag bit 1 is set, and only when the full 16-bit count equals {high match, low match} on a tick; the count then goes to 0. Flag bit 0 is never set in these modes.
- R9: In a split mode, `cap_lo_stb` copies the low count and `cap_hi_stb` copies the high count. The value copied is the count register as it stands in the cycle the strobe is high.
- R10: In a joined mode, either capture strobe copies the full 16-bit count into {high capture, low capture}.
- R11: Flags stay set until software writes 1 to their bit at address 8. If a set and a clear fall in the same cycle, the set wins. `irq_lo` always follows flag bit 0 and `irq_hi` follows flag bit 1.
- R12: A write to the control register clears both counts and the prescaler on that edge; no tick is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for both write and read |
| reg_wdata | input | HALF_W | Write data |
| reg_rdata | output | HALF_W | Combinational read data of the addressed register |
| evt_stb | input | 1 | One-cycle synchronised external event strobe |
| cap_lo_stb | input | 1 | Low-half capture strobe |
| cap_hi_stb | input | 1 | High-half capture strobe |
| irq_lo | output | 1 | Low-half match interrupt (flag bit 0) |
| irq_hi | output | 1 | High-half / joined match interrupt (flag bit 1) |

## Verification
Counts, captures and flags all update on the same edge that sees the tick, strobe or bus write. They appear on `reg_rdata` and on the interrupt pins straight after that edge, with no extra pipeline stage. The bench therefore advances its reference model once per rising edge and compares at the following falling edge. It holds the read address steady across the edge so that the value it compares is the post-edge one. Directed sequences work out the exact cycle counts for the prescaler period, wrap-to-zero, the 16-bit carry match and the clear on a control write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_PRESC  = 4'd1;
    localparam logic [ADDR_W-1:0] A_MLO    = 4'd2;
    localparam logic [ADDR_W-1:0] A_MHI    = 4'd3;
    localparam logic [ADDR_W-1:0] A_CNTLO  = 4'd4;
    localparam logic [ADDR_W-1:0] A_CNTHI  = 4'd5;
    localparam logic [ADDR_W-1:0] A_CAPLO  = 4'd6;
    localparam logic [ADDR_W-1:0] A_CAPHI  = 4'd7;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd8;

    typedef enum logic [1:0] {
        MODE_SPLIT_TMR = 2'd0,  // both halves prescaled
        MODE_SPLIT_MIX = 2'd1,  // low prescaled, high events
        MODE_JOIN_TMR  = 2'd2,  // 16-bit prescaled
        MODE_JOIN_EVT  = 2'd3   // 16-bit events
    } tmr_mode_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [PRE_W-1:0] reload,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = 1'b0;
        if (clr || !run) begin
            s_d.cnt = '0;
        end else if (s_q.cnt >= reload) begin
            s_d.cnt = '0;
            tick    = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || reload == '0));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int HALF_W = 8,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    input  logic              set_lo,
    input  logic              set_hi,
    output tmr_mode_e         mode,
    output logic              run,
    output logic              clr,
    output logic [PRE_W-1:0]  presc,
    output logic [HALF_W-1:0] match_lo,
    output logic [HALF_W-1:0] match_hi,
    output logic              flag_lo,
    output logic              flag_hi
);
    typedef struct packed {
        tmr_mode_e         mode;
        logic              run;
        logic [PRE_W-1:0]  presc;
        logic [HALF_W-1:0] mlo;
        logic [HALF_W-1:0] mhi;
        logic              flo;
        logic              fhi;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        clr = we && (addr == A_CTRL);
        if (we) begin
            case (addr)
                A_CTRL: begin
                    s_d.mode = tmr_mode_e'(wdata[1:0]);
                    s_d.run  = wdata[2];
                end
                A_PRESC: s_d.presc = wdata[PRE_W-1:0];
                A_MLO:   s_d.mlo   = wdata;
                A_MHI:   s_d.mhi   = wdata;
                A_FLAGS: begin
                    if (wdata[0]) s_d.flo = 1'b0;
                    if (wdata[1]) s_d.fhi = 1'b0;
                end
                default: ;
            endcase
        end
        if (set_lo) s_d.flo = 1'b1;
        if (set_hi) s_d.fhi = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mode     = s_q.mode;
    assign run      = s_q.run;
    assign presc    = s_q.presc;
    assign match_lo = s_q.mlo;
    assign match_hi = s_q.mhi;
    assign flag_lo  = s_q.flo;
    assign flag_hi  = s_q.fhi;

    // R8
    joined_no_lo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_JOIN_TMR || s_q.mode == MODE_JOIN_EVT) |-> !set_lo);

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fhi && !(we && addr == A_FLAGS && wdata[1])) |=> s_q.fhi);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_mode_e         mode,
    input  logic              run,
    input  logic              clr,
    input  logic              ptick,
    input  logic              evt_stb,
    input  logic              cap_lo_stb,
    input  logic              cap_hi_stb,
    input  logic [HALF_W-1:0] match_lo,
    input  logic [HALF_W-1:0] match_hi,
    output logic [HALF_W-1:0] cnt_lo,
    output logic [HALF_W-1:0] cnt_hi,
    output logic [HALF_W-1:0] cap_lo,
    output logic [HALF_W-1:0] cap_hi,
    output logic              set_lo,
    output logic              set_hi
);
    localparam int FULL_W = 2 * HALF_W;

    typedef struct packed {
        logic [HALF_W-1:0] lo;
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] cap_lo;
        logic [HALF_W-1:0] cap_hi;
    } core_t;

    core_t s_d, s_q;

    logic              joined;
    logic              evt;
    logic              lo_tick;
    logic              hi_tick;
    logic [FULL_W-1:0] full_q;
    logic [FULL_W-1:0] full_inc;

    assign joined   = (mode == MODE_JOIN_TMR) || (mode == MODE_JOIN_EVT);
    assign evt      = evt_stb && run;
    assign lo_tick  = (mode == MODE_JOIN_EVT) ? evt : ptick;
    assign hi_tick  = (mode == MODE_SPLIT_TMR) ? ptick : evt;
    assign full_q   = {s_q.hi, s_q.lo};
    assign full_inc = full_q + 1'b1;

    always_comb begin
        s_d    = s_q;
        set_lo = 1'b0;
        set_hi = 1'b0;

        // counting
        if (clr) begin
            s_d.lo = '0;
            s_d.hi = '0;
        end else if (joined) begin
            if (lo_tick) begin
                if (full_q == {match_hi, match_lo}) begin
                    s_d.lo = '0;
                    s_d.hi = '0;
                    set_hi = 1'b1;
                end else begin
                    {s_d.hi, s_d.lo} = full_inc;
                end
            end
        end else begin
            if (lo_tick) begin
                if (s_q.lo == match_lo) begin
                    s_d.lo = '0;
                    set_lo = 1'b1;
                end else begin
                    s_d.lo = s_q.lo + 1'b1;
                end
            end
            if (hi_tick) begin
                if (s_q.hi == match_hi) begin
                    s_d.hi = '0;
                    set_hi = 1'b1;
                end else begin
                    s_d.hi = s_q.hi + 1'b1;
                end
            end
        end

        // capture of the count as it stands this cycle
        if (joined) begin
            if (cap_lo_stb || cap_hi_stb) begin
                s_d.cap_lo = s_q.lo;
                s_d.cap_hi = s_q.hi;
            end
        end else begin
            if (cap_lo_stb) s_d.cap_lo = s_q.lo;
            if (cap_hi_stb) s_d.cap_hi = s_q.hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_lo = s_q.lo;
    assign cnt_hi = s_q.hi;
    assign cap_lo = s_q.cap_lo;
    assign cap_hi = s_q.cap_hi;

    // R7
    lo_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!joined && lo_tick && !clr && s_q.lo == match_lo) |=> (s_q.lo == '0));

    // R9
    split_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!joined && cap_lo_stb) |=> (s_q.cap_lo == $past(s_q.lo)));

    // R10
    joined_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (joined && (cap_lo_stb || cap_hi_stb)) |=>
            ({s_q.cap_hi, s_q.cap_lo} == $past({s_q.hi, s_q.lo})));
endmodule

// File: rtl/dual_timer_cap.sv
module dual_timer_cap
    import tmr_pkg::*;
#(
    parameter int HALF_W = 8,
    parameter int PRE_W  = 8   // must not exceed HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [HALF_W-1:0] reg_wdata,
    output logic [HALF_W-1:0] reg_rdata,
    input  logic              evt_stb,
    input  logic              cap_lo_stb,
    input  logic              cap_hi_stb,
    output logic              irq_lo,
    output logic              irq_hi
);
    tmr_mode_e         mode;
    logic              run;
    logic              clr;
    logic              ptick;
    logic [PRE_W-1:0]  presc;
    logic [HALF_W-1:0] match_lo, match_hi;
    logic [HALF_W-1:0] cnt_lo, cnt_hi, cap_lo, cap_hi;
    logic              set_lo, set_hi;
    logic              flag_lo, flag_hi;

    tmr_regs #(.HALF_W(HALF_W), .PRE_W(PRE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .set_lo   (set_lo),
        .set_hi   (set_hi),
        .mode     (mode),
        .run      (run),
        .clr      (clr),
        .presc    (presc),
        .match_lo (match_lo),
        .match_hi (match_hi),
        .flag_lo  (flag_lo),
        .flag_hi  (flag_hi)
    );

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .clr    (clr),
        .reload (presc),
        .tick   (ptick)
    );

    tmr_core #(.HALF_W(HALF_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .run        (run),
        .clr        (clr),
        .ptick      (ptick),
        .evt_stb    (evt_stb),
        .cap_lo_stb (cap_lo_stb),
        .cap_hi_stb (cap_hi_stb),
        .match_lo   (match_lo),
        .match_hi   (match_hi),
        .cnt_lo     (cnt_lo),
        .cnt_hi     (cnt_hi),
        .cap_lo     (cap_lo),
        .cap_hi     (cap_hi),
        .set_lo     (set_lo),
        .set_hi     (set_hi)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:  reg_rdata[2:0] = {run, mode};
            A_PRESC: reg_rdata[PRE_W-1:0] = presc;
            A_MLO:   reg_rdata = match_lo;
            A_MHI:   reg_rdata = match_hi;
            A_CNTLO: reg_rdata = cnt_lo;
            A_CNTHI: reg_rdata = cnt_hi;
            A_CAPLO: reg_rdata = cap_lo;
            A_CAPHI: reg_rdata = cap_hi;
            A_FLAGS: reg_rdata[1:0] = {flag_hi, flag_lo};
            default: reg_rdata = '0;
        endcase
    end

    assign irq_lo = flag_lo;
    assign irq_hi = flag_hi;
endmodule

// File: tb/sim_dual_timer_cap.sv
module sim_dual_timer_cap;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       ev = 1'b0, c0 = 1'b0, c1 = 1'b0;
    logic       irq_lo, irq_hi;

    always #10 clk = ~clk;   // 50 MHz

    dual_timer_cap u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .evt_stb(ev), .cap_lo_stb(c0), .cap_hi_stb(c1),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    // reference model state
    int m_mode, m_run, m_p, m_mlo, m_mhi, m_pc, m_lo, m_hi, m_caplo, m_caphi, m_flo, m_fhi;

    function automatic void m_reset();
        m_mode = 0; m_run = 0; m_p = 0; m_mlo = 0; m_mhi = 0; m_pc = 0;
        m_lo = 0; m_hi = 0; m_caplo = 0; m_caphi = 0; m_flo = 0; m_fhi = 0;
    endfunction

    // one rising edge of the specified behaviour
    function automatic void m_step(bit w, int a, int d, bit e, bit k0, bit k1);
        bit tick = 0, lt, ht, clr, sl = 0, sh = 0;
        int n16;
        clr = w && (a == 0);
        if (m_mode >= 2) begin
            if (k0 || k1) begin m_caplo = m_lo; m_caphi = m_hi; end   // R10
        end else begin
            if (k0) m_caplo = m_lo;                                     // R9
            if (k1) m_caphi = m_hi;
        end
        if (clr || m_run == 0) m_pc = 0;                                // R2, R12
        else if (m_pc >= m_p) begin m_pc = 0; tick = 1; end
        else m_pc++;
        lt = (m_mode == 3) ? (e && m_run != 0) : tick;
        ht = (m_mode == 0) ? tick : (e && m_run != 0);
        if (clr) begin m_lo = 0; m_hi = 0; end
        else if (m_mode >= 2) begin
            if (lt) begin
                n16 = m_hi * 256 + m_lo;
                if (n16 == m_mhi * 256 + m_mlo) begin n16 = 0; sh = 1; end   // R8
                else n16 = (n16 + 1) & 16'hffff;
                m_hi = n16 >> 8; m_lo = n16 & 255;
            end
        end else begin
            if (lt) begin
                if (m_lo == m_mlo) begin m_lo = 0; sl = 1; end else m_lo = (m_lo + 1) & 255;
            end
            if (ht) begin
                if (m_hi == m_mhi) begin m_hi = 0; sh = 1; end else m_hi = (m_hi + 1) & 255;
            end
        end
        if (w) begin
            case (a)
                0: begin m_mode = d & 3; m_run = (d >> 2) & 1; end
                1: m_p = d;
                2: m_mlo = d;
                3: m_mhi = d;
                8: begin if (d & 1) m_flo = 0; if (d & 2) m_fhi = 0; end
                default: ;
            endcase
        end
        if (sl) m_flo = 1;
        if (sh) m_fhi = 1;
    endfunction

    function automatic int m_read(int a);
        case (a)
            0: return m_run * 4 + m_mode;
            1: return m_p;
            2: return m_mlo;
            3: return m_mhi;
            4: return m_lo;
            5: return m_hi;
            6: return m_caplo;
            7: return m_caphi;
            8: return m_fhi * 2 + m_flo;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int a);
        if (a == 4 || a == 5) begin
            case (m_mode)
                0: return "R3";
                1: return "R4";
                2: return "R5";
                default: return "R6";
            endcase
        end
        if (a == 6 || a == 7) return (m_mode < 2) ? "R9" : "R10";
        if (a == 8) return (m_mode < 2) ? "R7" : "R8";
        return "R12";
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, model the rising edge, compare at next falling edge
    task automatic cyc(bit w, int a, int d, bit e, bit k0, bit k1);
        we = w; addr = 4'(a); wdata = 8'(d); ev = e; c0 = k0; c1 = k1;
        m_step(w, a, d, e, k0, k1);
        @(negedge clk);
        chk(tag_of(a), int'(rdata), m_read(a));
        chk("R11", int'(irq_lo), m_flo);
        chk("R11", int'(irq_hi), m_fhi);
    endtask

    task automatic idle(int a, int n);
        for (int i = 0; i < n; i++) cyc(0, a, 0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a <= 8; a++) begin
            addr = 4'(a);
            #1;
            chk("R1", int'(rdata), 0);
        end
        chk("R1", int'(irq_lo), 0);
        chk("R1", int'(irq_hi), 0);

        // R2: P=3 gives a tick every 4 cycles
        cyc(1, 1, 3, 0, 0, 0);
        cyc(1, 2, 200, 0, 0, 0);
        cyc(1, 3, 200, 0, 0, 0);
        cyc(1, 0, 4, 0, 0, 0);
        idle(4, 8);
        chk("R2", int'(rdata), 2);
        idle(4, 3);
        chk("R2", int'(rdata), 2);
        idle(4, 1);
        chk("R2", int'(rdata), 3);

        // R12: control write clears the count
        cyc(1, 0, 4, 0, 0, 0);
        idle(4, 1);
        chk("R12", int'(rdata), 0);

        // R7: P=0, low match 2 -> wraps on third edge
        cyc(1, 1, 0, 0, 0, 0);
        cyc(1, 2, 2, 0, 0, 0);
        cyc(1, 8, 3, 0, 0, 0);
        cyc(1, 0, 4, 0, 0, 0);
        idle(4, 2);
        chk("R7", int'(rdata), 2);
        chk("R7", int'(irq_lo), 0);
        idle(4, 1);
        chk("R7", int'(rdata), 0);
        chk("R7", int'(irq_lo), 1);

        // R8: joined prescaled, match 0x0102 -> flag after 259 ticks
        cyc(1, 2, 2, 0, 0, 0);
        cyc(1, 3, 1, 0, 0, 0);
        cyc(1, 0, 6, 0, 0, 0);
        cyc(1, 8, 3, 0, 0, 0);
        idle(8, 257);
        chk("R8", int'(rdata), 0);
        idle(8, 1);
        chk("R8", int'(rdata), 2);
        chk("R8", int'(irq_lo), 0);

        // R11: sticky, selective clear
        idle(8, 5);
        chk("R11", int'(rdata), 2);
        cyc(1, 8, 1, 0, 0, 0);
        chk("R11", int'(rdata), 2);
        cyc(1, 8, 2, 0, 0, 0);
        chk("R11", int'(rdata), 0);
        chk("R11", int'(irq_hi), 0);

        // random phase across all modes
        for (int md = 0; md < 4; md++) begin
            cyc(1, 1, int'($urandom % 4), 0, 0, 0);
            cyc(1, 2, (md < 2) ? int'($urandom % 16) : int'($urandom % 256), 0, 0, 0);
            cyc(1, 3, (md < 2) ? int'($urandom % 16) : int'($urandom % 2), 0, 0, 0);
            cyc(1, 0, md + 4, 0, 0, 0);
            cyc(1, 8, 3, 0, 0, 0);
            for (int i = 0; i < 900; i++) begin
                int r = int'($urandom % 100);
                bit e = 1'($urandom % 2);
                bit k0 = ($urandom % 12) == 0;
                bit k1 = ($urandom % 12) == 0;
                if (r < 3)       cyc(1, 8, int'($urandom % 4), e, k0, k1);
                else if (r == 3) cyc(1, 0, md + 4, e, k0, k1);
                else if (r == 4) cyc(1, 1, int'($urandom % 4), e, k0, k1);
                else             cyc(0, int'($urandom % 10), 0, e, k0, k1);
            end
        end

        // run disabled: no counting (R2)
        cyc(1, 0, 1, 0, 0, 0);
        for (int i = 0; i < 10; i++) cyc(0, 5, 0, 1, 0, 0);
        chk("R2", int'(rdata), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule